// File: doc/BRIEF.md
# LIN Auto-Baud Sync Measurement

This block measures the bit rate of a LIN master from the sync character 0x55 that follows the break. Once armed, it counts system clock cycles from the falling edge of the start bit to the falling edge of data bit 7. That span is eight bit times, because the character alternates low and high and is sent LSB first. From the count it forms the 16-bit divisor X of a UART whose bit rate is Fclk / (4·(X+1)). It then presents that divisor to the UART together with a one-cycle strobe.

A measurement is accepted only if all of the following hold:

- the cycle count lies within a programmed percentage window around the nominal count;
- the resulting divisor is above a minimum;
- no gap between falling edges exceeds a timeout.

Any other outcome raises a one-cycle sync error strobe and leaves the previous divisor in place.

All edge detection runs on a majority-of-three filtered copy of the receive line, and that filtered line is also brought out. The receive input is expected to be synchronized to the clock already. The sequencer that decides when a sync field is due, and the UART framing itself, sit outside this block.

Top module: `lin_baud_sync`

## Requirements
- R1: After reset `baud_div` equals the parameter NOM_DIV (27 by default), and `div_valid`, `sync_err` are 0 and `rx_maj` is 1.
- R2: `rx_maj` is the majority of the last three clock samples of `rx_in`. A low pulse of one cycle never shows on `rx_maj`; a low pulse of three cycles does.
- R3: A measurement starts only at the first filtered falling edge after an `arm` pulse. Falling edges while not armed produce no strobe and leave `baud_div` unchanged.
- R4: The measured count is the number of cycles from the 1st to the 5th filtered falling edge (8 bit times). The divisor is floor((count+16)/32) − 1, so halves round up. Bit periods of 112, 117 and 118 cycles give 27, 28 and 29.
- R5: With NOM_CNT = 32·(NOM_DIV+1), a count outside [floor(NOM_CNT·(100−ERR_PCT)/100), floor(NOM_CNT·(100+ERR_PCT)/100)] raises `sync_err`. With defaults (ERR_PCT = 15) the window is [761, 1030] cycles, so a 130-cycle bit (1040) and a 95-cycle bit (760) fail, and a 128-cycle bit gives 31.
- R6: A divisor of MIN_DIV (25) or less raises `sync_err`: a 104-cycle bit (divisor 25) fails, and a 106-cycle bit gives 26.
- R7: Once the span has started, if no further falling edge arrives within EDGE_TMO cycles of the previous one, the measurement ends with `sync_err`.
- R8: `baud_div` changes only in the cycle where `div_valid` is 1. A failed measurement leaves it as it was.
- R9: Each measurement ends with exactly one one-cycle strobe, either `div_valid` or `sync_err` and never both. The block then stays idle until armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Receive line, already synchronized to clk, idle high |
| arm | input | 1 | One-cycle pulse: expect a sync character next |
| rx_maj | output | 1 | Majority-of-three filtered receive line |
| baud_div | output | 16 | Current UART divisor X |
| div_valid | output | 1 | One-cycle strobe: new divisor accepted |
| sync_err | output | 1 | One-cycle strobe: measurement rejected or timed out |

## Verification
The assertions assume that `rx_in` is already synchronous to `clk` and that `arm` is a short pulse. They also assume that a valid sync field arrives as five clean falling edges, each less than EDGE_TMO cycles after the previous one. The bench drives `rx_in` and `arm` only on falling clock edges and holds each bit for a whole number of cycles. Measured counts are therefore exact multiples of the bit period, and the expected divisors and window decisions can be worked out by hand. Glitches and timeouts are injected only where a scenario is meant to exercise them, and `arm` is never pulsed in the middle of a span.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  // bit times covered between first and last measured falling edge
  localparam int unsigned SPAN_BITS = 8;
  // UART samples per bit in the divisor relation rate = Fclk/(4(X+1))
  localparam int unsigned OVS       = 4;
  localparam int unsigned EDGES     = SPAN_BITS / 2 + 1;
  localparam int unsigned SHIFT     = $clog2(OVS * SPAN_BITS);

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_HUNT,
    MS_SPAN
  } meas_st_e;
endpackage

// File: rtl/lbs_vote.sv
module lbs_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_maj
);
  logic [2:0] smp_q;
  logic       maj_q;
  logic       maj_d;

  assign maj_d = (smp_q[0] & smp_q[1]) | (smp_q[1] & smp_q[2]) | (smp_q[0] & smp_q[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '1;
      maj_q <= 1'b1;
    end else begin
      smp_q <= {smp_q[1:0], rx_in};
      maj_q <= maj_d;
    end
  end

  assign rx_maj = maj_q;

  // R2: a lone low sample between two highs never reaches the output
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_q == 3'b101) |=> maj_q);
endmodule

// File: rtl/lbs_fedge.sv
module lbs_fedge (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line;
  end

  assign fall = prev_q & ~line;
endmodule

// File: rtl/lbs_meas.sv
module lbs_meas #(
  parameter int unsigned CW       = 22,
  parameter int unsigned EDGE_TMO = 1 << 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          fall,
  output logic          done,
  output logic          tmo,
  output logic [CW-1:0] count
);
  import lbs_pkg::*;

  localparam int unsigned GW = $clog2(EDGE_TMO + 1);
  localparam int unsigned EW = $clog2(EDGES + 1);

  meas_st_e      st_q;
  logic [CW-1:0] span_q;
  logic [CW-1:0] cap_q;
  logic [GW-1:0] gap_q;
  logic [EW-1:0] nedge_q;
  logic          done_q;
  logic          tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MS_IDLE;
      span_q  <= '0;
      cap_q   <= '0;
      gap_q   <= '0;
      nedge_q <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      if (arm) begin
        st_q <= MS_HUNT;
      end else begin
        case (st_q)
          MS_HUNT: begin
            if (fall) begin
              st_q    <= MS_SPAN;
              span_q  <= CW'(1);
              gap_q   <= GW'(1);
              nedge_q <= EW'(1);
            end
          end
          MS_SPAN: begin
            if (span_q != '1) span_q <= span_q + CW'(1);
            if (fall) begin
              gap_q   <= GW'(1);
              nedge_q <= nedge_q + EW'(1);
              if (nedge_q == EW'(EDGES - 1)) begin
                cap_q  <= span_q;
                done_q <= 1'b1;
                st_q   <= MS_IDLE;
              end
            end else if (gap_q >= GW'(EDGE_TMO)) begin
              tmo_q <= 1'b1;
              st_q  <= MS_IDLE;
            end else begin
              gap_q <= gap_q + GW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done  = done_q;
  assign tmo   = tmo_q;
  assign count = cap_q;

  // R9
  one_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && tmo_q));
  // R7
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_SPAN) |-> (gap_q <= GW'(EDGE_TMO)));
  // R4
  edge_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_SPAN) |-> (nedge_q < EW'(EDGES) && nedge_q != '0));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_IDLE && !arm) |=> !done_q && !tmo_q);
endmodule

// File: rtl/lbs_judge.sv
module lbs_judge #(
  parameter int unsigned CW      = 22,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned NOM_DIV = 27,
  parameter int unsigned ERR_PCT = 15,
  parameter int unsigned MIN_DIV = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             tmo,
  input  logic [CW-1:0]    count,
  output logic [DIV_W-1:0] div,
  output logic             div_valid,
  output logic             sync_err
);
  import lbs_pkg::*;

  localparam longint NOM_CNT = longint'(NOM_DIV + 1) * longint'(OVS * SPAN_BITS);
  localparam longint LO_L    = NOM_CNT * longint'(100 - ERR_PCT) / 100;
  localparam longint HI_L    = NOM_CNT * longint'(100 + ERR_PCT) / 100;
  localparam logic [CW-1:0] LO_C   = LO_L[CW-1:0];
  localparam logic [CW-1:0] HI_C   = HI_L[CW-1:0];
  localparam logic [CW-1:0] HALF_C = CW'(1) << (SHIFT - 1);
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_DIV);
  localparam logic [CW-1:0] MAX_C  = CW'((64'd1 << DIV_W) - 64'd1);

  logic [CW-1:0]    rnd;
  logic [CW-1:0]    cand;
  logic             sat;
  logic             in_win;
  logic             in_rng;
  logic             accept;
  logic [DIV_W-1:0] div_q;
  logic             valid_q;
  logic             err_q;

  always_comb begin
    sat    = (count == '1);
    rnd    = (count + HALF_C) >> SHIFT;
    cand   = rnd - CW'(1);
    in_win = (count >= LO_C) && (count <= HI_C);
    in_rng = (cand > MIN_C) && (cand <= MAX_C) && (rnd != '0);
    accept = !sat && in_win && in_rng;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(NOM_DIV);
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= done && accept;
      err_q   <= tmo || (done && !accept);
      if (done && accept) div_q <= cand[DIV_W-1:0];
    end
  end

  assign div       = div_q;
  assign div_valid = valid_q;
  assign sync_err  = err_q;

  // R9
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && err_q));
  // R9
  short_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q || err_q) |=> !(valid_q || err_q));
  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> valid_q);
  // R6
  div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (div_q > DIV_W'(MIN_DIV)));
endmodule

// File: rtl/lin_baud_sync.sv
module lin_baud_sync #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned NOM_DIV  = 27,
  parameter int unsigned ERR_PCT  = 15,
  parameter int unsigned MIN_DIV  = 25,
  parameter int unsigned EDGE_TMO = 1 << 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             arm,
  output logic             rx_maj,
  output logic [DIV_W-1:0] baud_div,
  output logic             div_valid,
  output logic             sync_err
);
  import lbs_pkg::*;

  localparam int unsigned CW = DIV_W + SHIFT + 1;

  logic          maj;
  logic          fall;
  logic          m_done;
  logic          m_tmo;
  logic [CW-1:0] m_cnt;

  lbs_vote u_vote (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_in  (rx_in),
    .rx_maj (maj)
  );

  lbs_fedge u_fedge (
    .clk   (clk),
    .rst_n (rst_n),
    .line  (maj),
    .fall  (fall)
  );

  lbs_meas #(
    .CW       (CW),
    .EDGE_TMO (EDGE_TMO)
  ) u_meas (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .fall  (fall),
    .done  (m_done),
    .tmo   (m_tmo),
    .count (m_cnt)
  );

  lbs_judge #(
    .CW      (CW),
    .DIV_W   (DIV_W),
    .NOM_DIV (NOM_DIV),
    .ERR_PCT (ERR_PCT),
    .MIN_DIV (MIN_DIV)
  ) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (m_done),
    .tmo       (m_tmo),
    .count     (m_cnt),
    .div       (baud_div),
    .div_valid (div_valid),
    .sync_err  (sync_err)
  );

  assign rx_maj = maj;
endmodule

// File: tb/sim_lin_baud_sync.sv
module sim_lin_baud_sync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_in = 1'b1;
  logic        arm = 1'b0;
  logic        rx_maj;
  logic [15:0] baud_div;
  logic        div_valid;
  logic        sync_err;

  int total = 0;
  int bad   = 0;
  int nv    = 0;
  int ne    = 0;
  bit fin   = 1'b0;

  always #5 clk = ~clk;

  lin_baud_sync #(
    .DIV_W    (16),
    .NOM_DIV  (27),
    .ERR_PCT  (15),
    .MIN_DIV  (25),
    .EDGE_TMO (1000)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_in     (rx_in),
    .arm       (arm),
    .rx_maj    (rx_maj),
    .baud_div  (baud_div),
    .div_valid (div_valid),
    .sync_err  (sync_err)
  );

  always @(negedge clk) begin
    if (div_valid) nv++;
    if (sync_err)  ne++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic arm_pulse();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // 0x55 LSB first: start 0, then 1,0,1,0,1,0,1,0, stop 1
  task automatic send_sync(input int bitc);
    logic [9:0] pat;
    pat = 10'b1_01010101_0;
    for (int i = 0; i < 10; i++) begin
      rx_in = pat[i];
      repeat (bitc) @(negedge clk);
    end
    rx_in = 1'b1;
  endtask

  task automatic run_sync(input bit do_arm, input int bitc, input int exp_v,
                          input int exp_e, input int exp_div, input string req);
    int v0, e0;
    v0 = nv; e0 = ne;
    if (do_arm) arm_pulse();
    send_sync(bitc);
    repeat (20) @(negedge clk);
    check(nv - v0 == exp_v, {req, " valid count"}, nv - v0, exp_v);
    check(ne - e0 == exp_e, {req, " error count"}, ne - e0, exp_e);
    check(int'(baud_div) == exp_div, {req, " divisor"}, int'(baud_div), exp_div);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(int'(baud_div) == 27, "R1 divisor after reset", int'(baud_div), 27);
    check(div_valid == 1'b0 && sync_err == 1'b0, "R1 strobes after reset",
          int'({div_valid, sync_err}), 0);
    check(rx_maj == 1'b1, "R1 rx_maj after reset", int'(rx_maj), 1);
  endtask

  task automatic t_nominal();
    run_sync(1'b1, 112, 1, 0, 27, "R4 nominal 112");
  endtask

  task automatic t_round();
    run_sync(1'b1, 117, 1, 0, 28, "R4 round 117");
    run_sync(1'b1, 118, 1, 0, 29, "R4 round 118");
  endtask

  task automatic t_window();
    run_sync(1'b1, 130, 0, 1, 29, "R5 above window R8 hold");
    run_sync(1'b1, 128, 1, 0, 31, "R5 inside window 128");
    run_sync(1'b1, 95, 0, 1, 31, "R5 below window R8 hold");
  endtask

  task automatic t_range();
    run_sync(1'b1, 104, 0, 1, 31, "R6 divisor 25 rejected");
    run_sync(1'b1, 106, 1, 0, 26, "R6 divisor 26 accepted");
  endtask

  task automatic t_timeout();
    int v0, e0;
    v0 = nv; e0 = ne;
    arm_pulse();
    rx_in = 1'b0;
    repeat (112) @(negedge clk);
    rx_in = 1'b1;
    repeat (1100) @(negedge clk);
    check(ne - e0 == 1, "R7 timeout error", ne - e0, 1);
    check(nv - v0 == 0, "R7 timeout no valid", nv - v0, 0);
    check(int'(baud_div) == 26, "R7 R8 divisor kept", int'(baud_div), 26);
  endtask

  task automatic t_unarmed();
    run_sync(1'b0, 112, 0, 0, 26, "R3 R9 not armed");
  endtask

  task automatic t_glitch();
    int lows;
    lows = 0;
    rx_in = 1'b0;
    repeat (3) @(negedge clk);
    rx_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!rx_maj) lows++;
    end
    check(lows > 0, "R2 three-cycle low passes", lows, 1);
    repeat (10) @(negedge clk);
    arm_pulse();
    lows = 0;
    rx_in = 1'b0;
    @(negedge clk);
    rx_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!rx_maj) lows++;
    end
    check(lows == 0, "R2 one-cycle low blocked", lows, 0);
    repeat (50) @(negedge clk);
    run_sync(1'b0, 112, 1, 0, 27, "R2 sync after glitch");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nominal();
    t_round();
    t_window();
    t_range();
    t_timeout();
    t_unarmed();
    t_glitch();
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule